// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Reporting

This block receives asynchronous serial frames on a single line. An external tick marks each oversampling point, and `OVS` ticks make one bit time. When the line falls, the block tests the start bit at the midpoint of the bit and drops it if the line has returned high.

After a valid start bit, the block collects 7 or 8 data bits, least significant first. It then samples an optional parity bit and one stop bit. The received character goes to a holding register, and a status field records any error.

Two single-cycle pulses report the result of each frame. The error pulse comes first and the completion pulse follows one cycle later. The completion pulse can be suppressed for frames that carry an error. Clearing the enable input aborts a frame in progress without any visible effect.

The configuration inputs are expected to stay stable while a frame is in flight. The tick generator and the register interface that connects the block to software sit outside it.

Top module: `uart_rx_err`

## Requirements
- R1: After a falling edge on the line, the block samples it after `OVS/2` ticks. If the line is high at that point, the block returns to idle: no pulse is raised and the buffer and status are unchanged.
- R2: Data bits arrive least significant bit first. `cfg_len8`=1 receives 8 bits. `cfg_len8`=0 receives 7 bits, and `rx_buf[7]` reads 0.
- R3: `cfg_par` selects the parity mode: 0 none, 1 zero, 2 odd, 3 even. In odd mode the data bits plus the parity bit must hold an odd number of ones, and in even mode an even number. A mismatch sets `rx_stat` bit 2 (value 4).
- R4: In none and zero modes no parity error is ever raised, whatever the value of the bit after the data.
- R5: Exactly one stop bit is sampled. If that bit is low, `rx_stat` bit 1 (value 2) is set.
- R6: If a frame completes while the previous character is still unread, `rx_stat` bit 0 (value 1) is set. A `buf_rd` pulse in the same cycle counts as a read that happened first.
- R7: Every completed frame loads `rx_buf`, including frames with errors.
- R8: `irq_err` pulses for one cycle in the cycle after the stop-bit sample when any status bit is set. `irq_done` pulses for one cycle in the cycle after that.
- R9: When `cfg_err_mask`=1 and the frame has an error, `irq_done` does not pulse. With the mask at 0 it pulses for every frame.
- R10: A `buf_rd` pulse clears `rx_stat` and leaves `rx_buf` unchanged. Each completed frame replaces the whole status with that frame's own flags.
- R11: While `rx_en` is 0 the block stays idle. Dropping `rx_en` during a frame ends it at once: `rx_buf` and `rx_stat` keep their values and no pulse is raised.
- R12: After reset, `rx_buf`=0, `rx_stat`=0 and both pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable; 0 aborts and holds idle |
| rxd | input | 1 | Serial data line, idle high |
| smp_tick | input | 1 | Oversampling tick, `OVS` per bit |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_par | input | 2 | Parity mode: 0 none, 1 zero, 2 odd, 3 even |
| cfg_err_mask | input | 1 | 1 = suppress completion pulse on error |
| buf_rd | input | 1 | Buffer read strobe; clears status and the unread state |
| rx_buf | output | 8 | Last received character |
| rx_stat | output | 3 | Error flags: 4 parity, 2 framing, 1 overrun |
| irq_err | output | 1 | Error pulse |
| irq_done | output | 1 | Completion pulse, one cycle after the error slot |

## Verification
Most faults surface within a single frame. A wrong bit counter or a wrong alignment of the shift register shows up as a shifted or truncated character in `rx_buf`, or as a misplaced parity or stop sample, and so as a false status code at the next frame end. A stale unread flag shows at the following frame as a spurious or missing overrun code.

The order and spacing of the pulses is checked against a cycle stamp, so a completion pulse that lands in the same cycle as the error pulse is caught on the first erroneous frame. Abort and glitch handling show up as pulses where none are expected, or as changes to the buffer or status.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } rx_state_e;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_ZERO = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_EVEN = 2'd3
   } par_mode_e;

   localparam int unsigned CHAR_W = 8;
   localparam int unsigned STAT_W = 3;
endpackage

// File: rtl/uart_rx_bitclk.sv
module uart_rx_bitclk #(
   parameter int unsigned OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic half_mode,
   input  logic tick,
   output logic hit
);
   localparam int unsigned CW   = $clog2(OVS);
   localparam int unsigned HALF = OVS / 2;

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim = half_mode ? CW'(HALF - 1) : CW'(OVS - 1);
   assign hit = run && tick && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (!run)      cnt <= '0;
      else if (hit)       cnt <= '0;
      else if (tick)      cnt <= cnt + 1'b1;
   end

   a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(OVS - 1));
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
   import uart_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              par_en,
   input  logic              bit_in,
   input  logic              len8,
   input  par_mode_e         mode,
   output logic [CHAR_W-1:0] data,
   output logic              perr
);
   logic [CHAR_W-1:0] sr;
   logic              acc;
   logic              total;

   assign total = acc ^ bit_in;
   assign data  = len8 ? sr : {1'b0, sr[CHAR_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         acc  <= 1'b0;
         perr <= 1'b0;
      end else if (clr) begin
         sr   <= '0;
         acc  <= 1'b0;
         perr <= 1'b0;
      end else if (shift_en) begin
         sr  <= {bit_in, sr[CHAR_W-1:1]};
         acc <= acc ^ bit_in;
      end else if (par_en) begin
         unique case (mode)
            PAR_ODD:  perr <= ~total;
            PAR_EVEN: perr <= total;
            default:  perr <= 1'b0;
         endcase
      end
   end

   a_r4_no_perr_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (par_en && !clr && !shift_en && (mode == PAR_NONE || mode == PAR_ZERO)) |=> !perr);
endmodule

// File: rtl/uart_rx_result.sv
module uart_rx_result
   import uart_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fe,
   input  logic [CHAR_W-1:0] data,
   input  logic              perr,
   input  logic              stop_bit,
   input  logic              err_mask,
   input  logic              rd,
   output logic [CHAR_W-1:0] rx_buf,
   output logic [STAT_W-1:0] rx_stat,
   output logic              irq_err,
   output logic              irq_done
);
   logic              unread;
   logic              pend;
   logic [STAT_W-1:0] flags;
   logic              any_err;

   assign flags   = {perr, ~stop_bit, unread & ~rd};
   assign any_err = |flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf   <= '0;
         rx_stat  <= '0;
         unread   <= 1'b0;
         pend     <= 1'b0;
         irq_err  <= 1'b0;
         irq_done <= 1'b0;
      end else begin
         irq_done <= pend;
         if (fe) begin
            rx_buf  <= data;
            rx_stat <= flags;
            unread  <= 1'b1;
            irq_err <= any_err;
            pend    <= ~(any_err & err_mask);
         end else begin
            irq_err <= 1'b0;
            pend    <= 1'b0;
            if (rd) begin
               rx_stat <= '0;
               unread  <= 1'b0;
            end
         end
      end
   end

   a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |=> !irq_err);
   a_r8_done_slot: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |-> $past(fe, 2));
   a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (fe && any_err && err_mask) |-> ##2 !irq_done);
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !fe) |=> (rx_stat == '0));
   a_r7_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      fe |=> (rx_buf == $past(data)));
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
   import uart_rx_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_en,
   input  logic        rxd,
   input  logic        smp_tick,
   input  logic        cfg_len8,
   input  logic [1:0]  cfg_par,
   input  logic        cfg_err_mask,
   input  logic        buf_rd,
   output logic [7:0]  rx_buf,
   output logic [2:0]  rx_stat,
   output logic        irq_err,
   output logic        irq_done
);
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must not exceed 4");
   end

   logic rxs;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rxs = rxd;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], rxd} >> 0;
      end
      assign rxs = chain[SYNC_STAGES-1];
   end

   rx_state_e st, st_nx;
   par_mode_e mode;
   logic [2:0] bidx;
   logic       hit;
   logic       run;
   logic       fe;
   logic       sh_clr;
   logic       sh_en;
   logic       par_en;
   logic [2:0] last_idx;
   logic [7:0] data;
   logic       perr;

   assign mode     = par_mode_e'(cfg_par);
   assign last_idx = cfg_len8 ? 3'd7 : 3'd6;
   assign run      = rx_en && (st != ST_IDLE);
   assign sh_clr   = (st == ST_START) && hit && !rxs;
   assign sh_en    = (st == ST_DATA) && hit;
   assign par_en   = (st == ST_PAR) && hit;
   assign fe       = (st == ST_STOP) && hit;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (!rxs) st_nx = ST_START;
         ST_START: if (hit) st_nx = rxs ? ST_IDLE : ST_DATA;
         ST_DATA:  if (hit && bidx == last_idx)
                      st_nx = (mode == PAR_NONE) ? ST_STOP : ST_PAR;
         ST_PAR:   if (hit) st_nx = ST_STOP;
         ST_STOP:  if (hit) st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
      if (!rx_en) st_nx = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         bidx <= '0;
      end else begin
         st <= st_nx;
         if (sh_clr)     bidx <= '0;
         else if (sh_en) bidx <= bidx + 1'b1;
      end
   end

   uart_rx_bitclk #(.OVS(OVS)) u_bitclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .half_mode (st == ST_START),
      .tick      (smp_tick),
      .hit       (hit)
   );

   uart_rx_shifter u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sh_clr),
      .shift_en (sh_en),
      .par_en   (par_en),
      .bit_in   (rxs),
      .len8     (cfg_len8),
      .mode     (mode),
      .data     (data),
      .perr     (perr)
   );

   uart_rx_result u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .fe       (fe),
      .data     (data),
      .perr     (perr),
      .stop_bit (rxs),
      .err_mask (cfg_err_mask),
      .rd       (buf_rd),
      .rx_buf   (rx_buf),
      .rx_stat  (rx_stat),
      .irq_err  (irq_err),
      .irq_done (irq_done)
   );

   a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!irq_err && $stable(rx_buf)));
   a_r2_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fe && !cfg_len8) |=> !rx_buf[7]);
   a_r4_no_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (fe && (mode == PAR_NONE || mode == PAR_ZERO)) |=> !rx_stat[2]);
   a_r1_start_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_START && hit && rxs) |=> (st == ST_IDLE));
endmodule

// File: tb/uart_rx_err_bench.sv
module uart_rx_err_bench;
   localparam int OVS = 8;
   localparam int DIV = 2;
   localparam int BITC = OVS * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       rxd = 1'b1;
   logic       smp_tick = 1'b0;
   logic       cfg_len8 = 1'b1;
   logic [1:0] cfg_par = 2'd0;
   logic       cfg_err_mask = 1'b0;
   logic       buf_rd = 1'b0;
   logic [7:0] rx_buf;
   logic [2:0] rx_stat;
   logic       irq_err;
   logic       irq_done;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int n_err = 0;
   int n_done = 0;
   int t_err = 0;
   int t_done = 0;
   int tdiv = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   uart_rx_err #(.OVS(OVS), .SYNC_STAGES(2)) u_uart_rx_err (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd), .smp_tick(smp_tick),
      .cfg_len8(cfg_len8), .cfg_par(cfg_par), .cfg_err_mask(cfg_err_mask),
      .buf_rd(buf_rd), .rx_buf(rx_buf), .rx_stat(rx_stat),
      .irq_err(irq_err), .irq_done(irq_done)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      tdiv = (tdiv + 1) % DIV;
      smp_tick <= (tdiv == 0);
      if (rst_n && irq_err)  begin n_err  <= n_err + 1;  t_err  <= cyc; end
      if (rst_n && irq_done) begin n_done <= n_done + 1; t_done <= cyc; end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr_mon();
      @(negedge clk);
      n_err = 0; n_done = 0; t_err = 0; t_done = 0;
   endtask

   task automatic hold(input bit v, input int n);
      rxd = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v);
      int nb;
      bit p;
      nb = cfg_len8 ? 8 : 7;
      p = 1'b0;
      hold(1'b0, BITC);
      for (int i = 0; i < nb; i++) begin
         p ^= d[i];
         hold(d[i], BITC);
      end
      if (cfg_par != 2'd0) begin
         case (cfg_par)
            2'd1: p = 1'b0;
            2'd2: p = ~p;
            default: p = p;
         endcase
         hold(p ^ bad_par, BITC);
      end
      hold(stop_v, BITC);
      hold(1'b1, BITC);
   endtask

   task automatic rd_pulse();
      buf_rd = 1'b1;
      @(negedge clk);
      buf_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_frame(input logic [7:0] eb, input logic [2:0] es,
                            input int ee, input int ed, input string req);
      check(rx_buf == eb, {req, " buffer"}, rx_buf, eb);
      check(rx_stat == es, {req, " status"}, rx_stat, es);
      check(n_err == ee, {req, " error pulses"}, n_err, ee);
      check(n_done == ed, {req, " done pulses"}, n_done, ed);
      if (ee == 1 && ed == 1)
         check(t_done == t_err + 1, "R8 done one cycle after error", t_done - t_err, 1);
   endtask

   initial begin
      logic [7:0] vals [5];
      logic [7:0] exp;
      vals = '{8'h00, 8'hA5, 8'hFF, 8'h3C, 8'h81};
      repeat (4) @(negedge clk);
      check(rx_buf == 8'h00 && rx_stat == 3'd0 && !irq_err && !irq_done,
            "R12 reset state", {rx_buf, rx_stat}, 0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      repeat (4) @(negedge clk);

      // R2 R3 R4 R7: clean sweep over length, parity and data
      for (int l = 0; l < 2; l++) begin
         for (int pm = 0; pm < 4; pm++) begin
            for (int v = 0; v < 5; v++) begin
               cfg_len8 = l[0];
               cfg_par = pm[1:0];
               clr_mon();
               send(vals[v], 1'b0, 1'b1);
               exp = l[0] ? vals[v] : {1'b0, vals[v][6:0]};
               chk_frame(exp, 3'd0, 0, 1, "R2 clean frame");
               rd_pulse();
            end
         end
      end

      // R3 R8 R9: injected parity errors, with and without mask
      for (int l = 0; l < 2; l++) begin
         for (int pm = 2; pm < 4; pm++) begin
            for (int m = 0; m < 2; m++) begin
               cfg_len8 = l[0];
               cfg_par = pm[1:0];
               cfg_err_mask = m[0];
               clr_mon();
               send(8'h5B, 1'b1, 1'b1);
               exp = l[0] ? 8'h5B : 8'h5B;
               chk_frame(exp, 3'd4, 1, m ? 0 : 1, "R3 R9 parity error");
               rd_pulse();
            end
         end
      end
      cfg_err_mask = 1'b0;

      // R4: flipped bit after the data in zero mode
      cfg_len8 = 1'b1; cfg_par = 2'd1;
      clr_mon();
      send(8'h77, 1'b1, 1'b1);
      chk_frame(8'h77, 3'd0, 0, 1, "R4 zero parity ignored");
      rd_pulse();

      // R5 R7: framing error keeps the data
      cfg_par = 2'd3;
      clr_mon();
      send(8'hC3, 1'b0, 1'b0);
      chk_frame(8'hC3, 3'd2, 1, 1, "R5 R7 framing error");
      rd_pulse();
      check(rx_stat == 3'd0 && rx_buf == 8'hC3, "R10 read clears status", rx_stat, 0);

      // R6: overrun
      cfg_par = 2'd0;
      clr_mon();
      send(8'h11, 1'b0, 1'b1);
      send(8'h22, 1'b0, 1'b1);
      check(rx_stat == 3'd1, "R6 overrun status", rx_stat, 1);
      check(rx_buf == 8'h22, "R6 R7 overrun buffer", rx_buf, 8'h22);
      check(n_err == 1 && n_done == 2, "R6 overrun pulses", n_err * 16 + n_done, 16 + 2);
      rd_pulse();

      // R10: next frame replaces the status
      cfg_par = 2'd2;
      clr_mon();
      send(8'h0F, 1'b1, 1'b1);
      check(rx_stat == 3'd4, "R10 first error", rx_stat, 4);
      send(8'hF0, 1'b0, 1'b1);
      check(rx_stat == 3'd1, "R10 status replaced", rx_stat, 1);
      rd_pulse();
      check(rx_stat == 3'd0 && rx_buf == 8'hF0, "R10 read keeps buffer", rx_buf, 8'hF0);

      // R1: short glitch rejected
      clr_mon();
      hold(1'b0, 3);
      hold(1'b1, 3 * BITC);
      check(n_err == 0 && n_done == 0 && rx_buf == 8'hF0, "R1 glitch rejected",
            n_err + n_done, 0);
      send(8'h99, 1'b0, 1'b1);
      check(rx_buf == 8'h99 && n_done == 1, "R1 frame after glitch", rx_buf, 8'h99);
      rd_pulse();

      // R11: abort mid-frame
      cfg_par = 2'd0;
      clr_mon();
      fork
         send(8'h6A, 1'b0, 1'b0);
         begin
            repeat (5 * BITC) @(negedge clk);
            rx_en = 1'b0;
         end
      join
      check(n_err == 0 && n_done == 0, "R11 abort no pulse", n_err + n_done, 0);
      check(rx_buf == 8'h99 && rx_stat == 3'd0, "R11 abort no change", rx_buf, 8'h99);

      // R11: disabled receiver ignores a whole frame
      clr_mon();
      send(8'h44, 1'b0, 1'b1);
      check(n_done == 0 && rx_buf == 8'h99, "R11 disabled ignores", rx_buf, 8'h99);
      rx_en = 1'b1;
      repeat (4) @(negedge clk);
      send(8'h44, 1'b0, 1'b1);
      check(rx_buf == 8'h44 && n_done == 1, "R11 re-enabled", rx_buf, 8'h44);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule